// File: doc/BRIEF.md
# ATM Cell Boundary Finder

This block recovers ATM cell boundaries from a received serial bit stream for one link. Each bit arrives with a valid strobe; bits of every octet come most significant first. The block checks the header error control octet over a sliding 40-bit window. Its state machine has three states: HUNT, PRESYNC and SYNC. Two run-length thresholds give the state machine hysteresis: a confirmation count for acquiring lock and a miss count for dropping it.

In HUNT the header check is tried at every bit position. After a match, the block steps one full 53-octet cell at a time. Once locked, it marks each cell start, presents the four header octets and a header-error flag, and streams the 48 payload octets. A separate monitor counts whole cell periods spent in HUNT and raises a loss-of-delineation flag when that count reaches a programmable threshold. Reaching SYNC clears the flag.

Top module: `cell_delin`

## Requirements
- R1: After reset, state_o is HUNT, and lcd_o, cell_start_o and oct_vld_o are 0.
- R2: state_o encodes HUNT as 0, PRESYNC as 1 and SYNC as 2. The value 3 never appears.
- R3: A header is correct when octet 5 equals a CRC-8 over octets 1 to 4, XORed with 0x55 when cfg_coset_en_i is 1. The CRC uses generator x^8+x^2+x+1, a zero initial value and is taken MSB first. With cfg_coset_en_i at 0, the plain CRC must match.
- R4: In HUNT, once 40 valid bits have arrived since reset, the header check runs on every valid bit. A match moves the block to PRESYNC, and that bit becomes the end of a header.
- R5: In PRESYNC, the check runs only at each cell boundary (424 valid bits after the previous header end). A single incorrect header returns the block to HUNT. cfg_delta_i consecutive correct headers after PRESYNC was entered move it to SYNC. Values below 1 act as 1.
- R6: In SYNC, cfg_alpha_i consecutive incorrect headers at cell boundaries return the block to HUNT. Any correct header resets the run. Values below 1 act as 1.
- R7: The cycle after a header end whose resulting state is SYNC, cell_start_o pulses for one cycle. In that same cycle, hdr_o holds header octets 1 to 4 (octet 1 in bits 31:24) and hdr_err_o is 1 when the header check failed.
- R8: Payload octets are output only while the state is SYNC. Each cell gives 48 octets in arrival order, each marked by a one-cycle oct_vld_o pulse after its last bit.
- R9: Every 424 valid bits spent in HUNT add one to a loss count. lcd_o is 1 while that count is at least cfg_lcd_thr_i, and a threshold of 0 disables the flag. Entering SYNC clears the count and lcd_o.
- R10: A cycle with bit_vld_i low changes no state, position or count, and produces no cell_start_o or oct_vld_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Received serial bit, MSB of each octet first |
| cfg_alpha_i | input | 4 | Consecutive bad headers that end SYNC |
| cfg_delta_i | input | 4 | Consecutive good headers needed in PRESYNC |
| cfg_coset_en_i | input | 1 | Apply the 0x55 coset in the header check |
| cfg_lcd_thr_i | input | 12 | Loss-of-delineation threshold in cells, 0 disables |
| cell_start_o | output | 1 | Pulse at each header end while locked |
| hdr_o | output | 32 | Header octets 1 to 4 of the latest locked cell |
| hdr_err_o | output | 1 | The latest locked header failed its check |
| oct_o | output | 8 | Payload octet |
| oct_vld_o | output | 1 | Pulse qualifying oct_o |
| state_o | output | 2 | Delineation state code |
| lcd_o | output | 1 | Loss-of-delineation flag |

## Verification
The assertions check rules that must hold on every cycle. The state code stays legal and HUNT never jumps straight to SYNC. Cell-start and payload pulses appear only while locked. The loss flag is never set in SYNC. An idle strobe leaves the state untouched and produces no pulse. Only the directed scenarios can show the counting rules: the exact header on which PRESYNC confirms or SYNC is lost, the header check with and without the coset, the payload octet values across idle gaps, and the exact bit on which the loss flag rises and the cell on which it clears.

// File: rtl/cell_delin_pkg.sv
package cell_delin_pkg;

   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_PRESYNC = 2'd1,
      ST_SYNC    = 2'd2
   } cd_state_e;

   localparam int          HDR_BITS  = 40;
   localparam logic [7:0]  HEC_GEN   = 8'h07;
   localparam logic [7:0]  HEC_COSET = 8'h55;

   // CRC-8 over the four leading header octets, MSB first, zero start
   function automatic logic [7:0] hec_calc(input logic [31:0] hdr);
      logic [7:0] crc;
      logic       fb;
      crc = '0;
      for (int i = 31; i >= 0; i--) begin
         fb  = crc[7] ^ hdr[i];
         crc = {crc[6:0], 1'b0};
         if (fb) crc = crc ^ HEC_GEN;
      end
      return crc;
   endfunction

endpackage

// File: rtl/cell_delin_hec.sv
module cell_delin_hec
   import cell_delin_pkg::*;
#(
   parameter bit COSET_OPT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_vld_i,
   input  logic                bit_i,
   input  logic                coset_en_i,
   output logic [HDR_BITS-1:0] win_nxt_o,
   output logic                hit_o,
   output logic                full_o
);

   localparam int FILL_W = $clog2(HDR_BITS + 1);
   localparam logic [FILL_W-1:0] FILL_MAX  = FILL_W'(HDR_BITS);
   localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(HDR_BITS - 1);

   logic [HDR_BITS-1:0] win_q;
   logic [FILL_W-1:0]   fill_q;
   logic [7:0]          mask;

   generate
      if (COSET_OPT) begin : g_coset_sel
         assign mask = coset_en_i ? HEC_COSET : 8'h00;
      end else begin : g_coset_fixed
         assign mask = HEC_COSET;
      end
   endgenerate

   assign win_nxt_o = {win_q[HDR_BITS-2:0], bit_i};
   assign hit_o     = (hec_calc(win_nxt_o[HDR_BITS-1:8]) ^ mask) == win_nxt_o[7:0];
   assign full_o    = fill_q >= FILL_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (bit_vld_i) begin
         win_q <= win_nxt_o;
         if (fill_q != FILL_MAX) fill_q <= fill_q + FILL_W'(1);
      end
   end

endmodule

// File: rtl/cell_delin_fsm.sv
module cell_delin_fsm
   import cell_delin_pkg::*;
#(
   parameter int CELL_BITS = 424,
   parameter int CNT_W     = 4,
   parameter int POS_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld_i,
   input  logic             hit_i,
   input  logic             full_i,
   input  logic [CNT_W-1:0] alpha_i,
   input  logic [CNT_W-1:0] delta_i,
   output cd_state_e        state_o,
   output cd_state_e        state_nxt_o,
   output logic [POS_W-1:0] pos_nxt_o,
   output logic             boundary_o,
   output logic             hunt_tick_o,
   output logic             sync_enter_o
);

   localparam logic [POS_W-1:0] CELL_END = POS_W'(CELL_BITS);

   cd_state_e        state_q;
   logic [POS_W-1:0] pos_q;
   logic [CNT_W-1:0] run_q, run_nxt;
   logic [CNT_W:0]   run_inc;
   logic             hunt_hit;

   assign pos_nxt_o   = pos_q + POS_W'(1);
   assign boundary_o  = bit_vld_i && (pos_nxt_o == CELL_END);
   assign hunt_hit    = bit_vld_i && (state_q == ST_HUNT) && full_i && hit_i;
   assign hunt_tick_o = boundary_o && (state_q == ST_HUNT);
   assign run_inc     = {1'b0, run_q} + (CNT_W+1)'(1);
   assign state_o     = state_q;

   always_comb begin
      state_nxt_o  = state_q;
      run_nxt      = run_q;
      sync_enter_o = 1'b0;
      unique case (state_q)
         ST_HUNT: begin
            if (hunt_hit) begin
               state_nxt_o = ST_PRESYNC;
               run_nxt     = '0;
            end
         end
         ST_PRESYNC: begin
            if (boundary_o) begin
               if (!hit_i) begin
                  state_nxt_o = ST_HUNT;
                  run_nxt     = '0;
               end else if (run_inc >= {1'b0, delta_i}) begin
                  state_nxt_o  = ST_SYNC;
                  run_nxt      = '0;
                  sync_enter_o = 1'b1;
               end else begin
                  run_nxt = run_inc[CNT_W-1:0];
               end
            end
         end
         ST_SYNC: begin
            if (boundary_o) begin
               if (hit_i) begin
                  run_nxt = '0;
               end else if (run_inc >= {1'b0, alpha_i}) begin
                  state_nxt_o = ST_HUNT;
                  run_nxt     = '0;
               end else begin
                  run_nxt = run_inc[CNT_W-1:0];
               end
            end
         end
         default: begin
            state_nxt_o = ST_HUNT;
            run_nxt     = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         run_q   <= '0;
         pos_q   <= '0;
      end else if (bit_vld_i) begin
         state_q <= state_nxt_o;
         run_q   <= run_nxt;
         if (hunt_hit || boundary_o) pos_q <= '0;
         else                        pos_q <= pos_nxt_o;
      end
   end

endmodule

// File: rtl/cell_delin_lcd.sv
module cell_delin_lcd #(
   parameter int LCD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hunt_tick_i,
   input  logic             sync_enter_i,
   input  logic [LCD_W-1:0] thr_i,
   output logic             lcd_o
);

   localparam logic [LCD_W-1:0] CNT_MAX = '1;

   logic [LCD_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sync_enter_i) begin
         cnt_q <= '0;
      end else if (hunt_tick_i && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + LCD_W'(1);
      end
   end

   assign lcd_o = (thr_i != '0) && (cnt_q >= thr_i);

endmodule

// File: rtl/cell_delin_out.sv
module cell_delin_out
   import cell_delin_pkg::*;
#(
   parameter int PAY_BITS = 384,
   parameter int POS_W    = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_vld_i,
   input  cd_state_e           state_i,
   input  cd_state_e           state_nxt_i,
   input  logic                boundary_i,
   input  logic                hit_i,
   input  logic [POS_W-1:0]    pos_nxt_i,
   input  logic [HDR_BITS-1:0] win_nxt_i,
   output logic                cell_start_o,
   output logic [31:0]         hdr_o,
   output logic                hdr_err_o,
   output logic [7:0]          oct_o,
   output logic                oct_vld_o
);

   localparam logic [POS_W-1:0] PAY_END = POS_W'(PAY_BITS);

   logic mark, pay_byte;

   assign mark     = boundary_i && (state_nxt_i == ST_SYNC);
   assign pay_byte = bit_vld_i && (state_i == ST_SYNC) && (pos_nxt_i[2:0] == 3'd0)
                     && (pos_nxt_i != '0) && (pos_nxt_i <= PAY_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cell_start_o <= 1'b0;
         hdr_o        <= '0;
         hdr_err_o    <= 1'b0;
         oct_o        <= '0;
         oct_vld_o    <= 1'b0;
      end else begin
         cell_start_o <= mark;
         oct_vld_o    <= pay_byte;
         if (mark) begin
            hdr_o     <= win_nxt_i[HDR_BITS-1:8];
            hdr_err_o <= !hit_i;
         end
         if (pay_byte) oct_o <= win_nxt_i[7:0];
      end
   end

endmodule

// File: rtl/cell_delin.sv
module cell_delin
   import cell_delin_pkg::*;
#(
   parameter int CELL_OCTETS = 53,
   parameter int CNT_W       = 4,
   parameter int LCD_W       = 12,
   parameter bit COSET_OPT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic [CNT_W-1:0] cfg_alpha_i,
   input  logic [CNT_W-1:0] cfg_delta_i,
   input  logic             cfg_coset_en_i,
   input  logic [LCD_W-1:0] cfg_lcd_thr_i,
   output logic             cell_start_o,
   output logic [31:0]      hdr_o,
   output logic             hdr_err_o,
   output logic [7:0]       oct_o,
   output logic             oct_vld_o,
   output logic [1:0]       state_o,
   output logic             lcd_o
);

   localparam int CELL_BITS = CELL_OCTETS * 8;
   localparam int PAY_BITS  = CELL_BITS - HDR_BITS;
   localparam int POS_W     = $clog2(CELL_BITS + 1);

   generate
      if (CELL_OCTETS < 6) begin : g_bad_cell
         $error("cell_delin: CELL_OCTETS must exceed the header length");
      end
      if (CNT_W < 1 || LCD_W < 1) begin : g_bad_width
         $error("cell_delin: counter widths must be positive");
      end
   endgenerate

   logic [HDR_BITS-1:0] win_nxt;
   logic                hit, full, boundary, hunt_tick, sync_enter;
   logic [POS_W-1:0]    pos_nxt;
   cd_state_e           state, state_nxt;

   cell_delin_hec #(.COSET_OPT(COSET_OPT)) u_hec (
      .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
      .coset_en_i(cfg_coset_en_i), .win_nxt_o(win_nxt), .hit_o(hit), .full_o(full)
   );

   cell_delin_fsm #(.CELL_BITS(CELL_BITS), .CNT_W(CNT_W), .POS_W(POS_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .hit_i(hit), .full_i(full),
      .alpha_i(cfg_alpha_i), .delta_i(cfg_delta_i), .state_o(state),
      .state_nxt_o(state_nxt), .pos_nxt_o(pos_nxt), .boundary_o(boundary),
      .hunt_tick_o(hunt_tick), .sync_enter_o(sync_enter)
   );

   cell_delin_lcd #(.LCD_W(LCD_W)) u_lcd (
      .clk(clk), .rst_n(rst_n), .hunt_tick_i(hunt_tick), .sync_enter_i(sync_enter),
      .thr_i(cfg_lcd_thr_i), .lcd_o(lcd_o)
   );

   cell_delin_out #(.PAY_BITS(PAY_BITS), .POS_W(POS_W)) u_out (
      .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .state_i(state),
      .state_nxt_i(state_nxt), .boundary_i(boundary), .hit_i(hit),
      .pos_nxt_i(pos_nxt), .win_nxt_i(win_nxt), .cell_start_o(cell_start_o),
      .hdr_o(hdr_o), .hdr_err_o(hdr_err_o), .oct_o(oct_o), .oct_vld_o(oct_vld_o)
   );

   assign state_o = state;

endmodule

// File: rtl/cell_delin_chk.sv
module cell_delin_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_vld_i,
   input logic       cell_start_o,
   input logic       oct_vld_o,
   input logic [1:0] state_o,
   input logic       lcd_o
);

   // R2: the unused code never shows
   a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd3);

   // R5: lock is only reached through PRESYNC
   a_r5_no_hunt_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 2'd0) |-> (state_o != 2'd2));

   // R7: cell markers only while locked
   a_r7_start_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start_o |-> (state_o == 2'd2));

   // R8: payload octets only come from a locked state
   a_r8_octet_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      oct_vld_o |-> ($past(state_o) == 2'd2));

   // R9: loss flag is cleared whenever locked
   a_r9_lcd_clear_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2) |-> !lcd_o);

   // R10: idle strobe moves nothing
   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_vld_i) |-> ($stable(state_o) && !cell_start_o && !oct_vld_o));

endmodule

bind cell_delin cell_delin_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .cell_start_o(cell_start_o),
   .oct_vld_o(oct_vld_o), .state_o(state_o), .lcd_o(lcd_o)
);

// File: tb/cell_delin_tb_top.sv
module cell_delin_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_vld = 1'b0;
   logic        bit_d = 1'b0;
   logic [3:0]  alpha = 4'd7;
   logic [3:0]  delta = 4'd6;
   logic        coset = 1'b1;
   logic [11:0] thr = 12'd0;
   logic        cell_start, hdr_err, oct_vld, lcd;
   logic [31:0] hdr;
   logic [7:0]  oct;
   logic [1:0]  state;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // results of the latest cell
   logic [1:0]  r_st;
   logic        r_cs, r_err;
   logic [31:0] r_hdr;
   int          ncap, cap_bad, gap_bad;
   logic [7:0]  cur_seed;

   always #5 clk = ~clk;

   cell_delin dut_i (
      .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld), .bit_i(bit_d),
      .cfg_alpha_i(alpha), .cfg_delta_i(delta), .cfg_coset_en_i(coset),
      .cfg_lcd_thr_i(thr), .cell_start_o(cell_start), .hdr_o(hdr),
      .hdr_err_o(hdr_err), .oct_o(oct), .oct_vld_o(oct_vld),
      .state_o(state), .lcd_o(lcd)
   );

   function automatic logic [7:0] tb_crc(input logic [31:0] h);
      logic [7:0] c = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         if (c[7] ^ h[i]) c = {c[6:0], 1'b0} ^ 8'h07;
         else             c = {c[6:0], 1'b0};
      end
      return c;
   endfunction

   function automatic logic [7:0] good_hec(input logic [31:0] h);
      return tb_crc(h) ^ (coset ? 8'h55 : 8'h00);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      bit_vld = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic send_bit(input logic b, input bit gap);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_d   = b;
      @(posedge clk);
      #1;
      bit_vld = 1'b0;
      if (oct_vld) begin
         if (oct !== 8'(cur_seed + 8'(ncap))) cap_bad++;
         ncap++;
      end
      if (gap) begin
         @(posedge clk);
         #1;
         if (cell_start || oct_vld) gap_bad++;
      end
   endtask

   task automatic send_cell(input logic [31:0] h, input logic [7:0] hec,
                            input logic [7:0] seed, input bit gaps);
      logic [39:0] hw = {h, hec};
      for (int i = 39; i >= 0; i--) send_bit(hw[i], 1'b0);
      r_st  = state;
      r_cs  = cell_start;
      r_hdr = hdr;
      r_err = hdr_err;
      cur_seed = seed;
      ncap = 0;
      cap_bad = 0;
      for (int i = 0; i < 384; i++) begin
         logic [7:0] by = seed + 8'(i / 8);
         send_bit(by[7 - (i % 8)], gaps && (i % 7 == 3));
      end
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 state", 32'(state), 32'd0);
      check("R1 lcd", 32'(lcd), 32'd0);
      check("R1 cell_start", 32'(cell_start), 32'd0);
      check("R1 oct_vld", 32'(oct_vld), 32'd0);
   endtask

   task automatic t_acquire();
      logic [31:0] h;
      alpha = 4'd7; delta = 4'd6; coset = 1'b1; thr = 12'd0;
      do_reset();
      for (int k = 0; k < 7; k++) begin
         h = 32'h0012_3A40 + 32'(k * 16);
         send_cell(h, good_hec(h), 8'(k * 3), 1'b0);
         if (k == 0)      check("R4 hunt match gives PRESYNC", 32'(r_st), 32'd1);
         else if (k < 6)  check("R5 PRESYNC before delta", 32'(r_st), 32'd1);
         else begin
            check("R5 SYNC after delta good headers", 32'(r_st), 32'd2);
            check("R7 cell_start at lock", 32'(r_cs), 32'd1);
            check("R7 header octets", r_hdr, h);
            check("R7 header error flag clear", 32'(r_err), 32'd0);
            check("R8 payload octet count", 32'(ncap), 32'd48);
            check("R8 payload octet values", 32'(cap_bad), 32'd0);
         end
      end
      gap_bad = 0;
      h = 32'h00AB_CDE0;
      send_cell(h, good_hec(h), 8'h90, 1'b1);
      check("R10 state held across idle gaps", 32'(r_st), 32'd2);
      check("R10 payload count with gaps", 32'(ncap), 32'd48);
      check("R10 payload values with gaps", 32'(cap_bad), 32'd0);
      check("R10 no pulses in idle cycles", 32'(gap_bad), 32'd0);
      check("R9 threshold 0 keeps lcd low", 32'(lcd), 32'd0);
   endtask

   task automatic t_loss();
      logic [31:0] h = 32'h0055_1230;
      for (int k = 0; k < 6; k++) begin
         send_cell(h, good_hec(h) ^ 8'h01, 8'h20, 1'b0);
         check("R6 SYNC held below alpha", 32'(r_st), 32'd2);
         if (k == 0) begin
            check("R7 cell_start on bad header", 32'(r_cs), 32'd1);
            check("R7 header error flag set", 32'(r_err), 32'd1);
         end
      end
      send_cell(h, good_hec(h), 8'h30, 1'b0);
      check("R6 good header resets miss run", 32'(r_st), 32'd2);
      check("R7 header error flag after good", 32'(r_err), 32'd0);
      for (int k = 0; k < 7; k++) begin
         send_cell(h, good_hec(h) ^ 8'h80, 8'h40, 1'b0);
         if (k < 6) check("R6 SYNC held in second run", 32'(r_st), 32'd2);
         else begin
            check("R6 HUNT after alpha bad headers", 32'(r_st), 32'd0);
            check("R8 no payload once unlocked", 32'(ncap), 32'd0);
         end
      end
   endtask

   task automatic t_presync_fail();
      logic [31:0] h = 32'h0077_0010;
      alpha = 4'd7; delta = 4'd6; coset = 1'b1;
      do_reset();
      send_cell(h, good_hec(h), 8'h00, 1'b0);
      check("R5 PRESYNC entered", 32'(r_st), 32'd1);
      send_cell(h, good_hec(h) ^ 8'h04, 8'h00, 1'b0);
      check("R5 single bad header leaves PRESYNC", 32'(r_st), 32'd0);
   endtask

   task automatic t_coset();
      logic [31:0] h = 32'h0101_0202;
      logic [7:0]  plain = tb_crc(h);
      coset = 1'b0;
      do_reset();
      send_cell(h, plain, 8'h00, 1'b0);
      check("R3 plain CRC accepted without coset", 32'(r_st), 32'd1);
      coset = 1'b1;
      do_reset();
      send_cell(h, plain, 8'h00, 1'b0);
      check("R3 plain CRC rejected with coset", 32'(r_st), 32'd0);
   endtask

   task automatic t_lcd();
      alpha = 4'd7; delta = 4'd2; coset = 1'b1; thr = 12'd3;
      do_reset();
      for (int i = 0; i < 3 * 424 - 1; i++) send_bit(1'b0, 1'b0);
      check("R9 lcd low one bit before threshold", 32'(lcd), 32'd0);
      send_bit(1'b0, 1'b0);
      check("R9 lcd high at threshold", 32'(lcd), 32'd1);
      check("R9 still HUNT", 32'(state), 32'd0);
      send_cell(32'h0, 8'h55, 8'h00, 1'b0);
      check("R9 lcd held in PRESYNC", 32'(lcd), 32'd1);
      check("R4 zero header acquired", 32'(r_st), 32'd1);
      send_cell(32'h0, 8'h55, 8'h00, 1'b0);
      check("R5 programmed delta not yet met", 32'(r_st), 32'd1);
      send_cell(32'h0, 8'h55, 8'h00, 1'b0);
      check("R5 programmed delta reached", 32'(r_st), 32'd2);
      check("R9 lcd cleared on SYNC", 32'(lcd), 32'd0);
      thr = 12'd0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_acquire();
      t_loss();
      t_presync_fail();
      t_coset();
      t_lcd();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule